// File: doc/BRIEF.md
# Serial Command Word Receiver

This block accepts command words from a three-wire serial port made of an active-low chip select, a serial clock and a data line. Each 24-bit word carries a 16-bit sample value, a 5-bit channel number and two mode bits. Every complete word becomes a one-cycle write request in the system clock domain, addressed to a 32-entry by 16-bit channel memory that sits outside this block. One chip-select frame may hold any number of back-to-back words.

The two mode bits of the last accepted word are kept. Each is ORed with an external pin to form the immediate-update flag and the external-sequencer-clock flag. The bits are not sticky across words: a word with a mode bit at 0 clears that bit. While the surrounding logic runs its reset initialisation, indicated by `init_busy`, completed words are dropped and the mode bits are left alone. A synchronised copy of the chip select tells the system side that a frame is open.

The serial clock is asynchronous to `clk`. Its period must be at least four `clk` periods so that the held word fields are stable when the system side takes them.

Top module: `cmd_word_rx`

## Requirements
- R1: Bits are sampled on the rising edge of `sclk` while `cs_n` is low, most significant bit first. The first rising edge after `cs_n` falls captures bit 23.
- R2: Word layout: bits 23..8 are the write data, bits 7..3 are the channel address in plain binary (0 to 31), bit 2 is the immediate-mode bit, bit 1 is the external-clock bit, and bit 0 is a fill bit that is ignored.
- R3: Each completed word produces exactly one `wr_en` pulse, one `clk` cycle long, with `wr_addr` and `wr_data` holding that word's fields. The pulse comes within 8 `clk` cycles of the 24th rising `sclk` edge.
- R4: Several words sent in one frame each produce their own write, in the order they were sent.
- R5: A rising `cs_n` clears the bit count. A word cut short by the end of a frame produces no write, and the next frame starts again at bit 23.
- R6: `imm_mode` and `ext_clk_sel` follow bits 2 and 1 of the most recently accepted word, and hold until the next accepted word. A word with a bit at 0 clears the matching flag.
- R7: `imm_mode` is the word's bit 2 OR `imm_pin`, and `ext_clk_sel` is the word's bit 1 OR `ext_clk_pin`. A pin change appears on the output one `clk` cycle later.
- R8: While `init_busy` is high, a completed word causes no write and leaves the mode bits unchanged.
- R9: `frame_active` is high when `cs_n` is low, delayed through a two-stage synchroniser, and low when `cs_n` is high.
- R10: After the synchronous reset `rst`, `wr_en`, `wr_addr`, `wr_data`, `imm_mode`, `ext_clk_sel` and `frame_active` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also clears the serial-side request state |
| cs_n | input | 1 | Active-low chip select that frames the words |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| din | input | 1 | Serial data in |
| imm_pin | input | 1 | External immediate-mode request |
| ext_clk_pin | input | 1 | External request to select the external sequencer clock |
| init_busy | input | 1 | High while a reset initialisation runs; serial words are dropped |
| wr_en | output | 1 | One-cycle write strobe for the channel memory |
| wr_addr | output | 5 | Channel address of the write |
| wr_data | output | 16 | Data of the write |
| imm_mode | output | 1 | Effective immediate-update flag |
| ext_clk_sel | output | 1 | Effective external-clock flag |
| frame_active | output | 1 | Synchronised chip-select-low indication |

## Verification
The bench goes after word framing. A frame cut off after ten bits must leave no write behind and must not shift the next frame by ten bits. A design that kept the count would write a garbled address and data. Three words sent in one frame must give three writes. A design that only handled one word per frame would lose the later ones.

An asymmetric data pattern and the addresses 0 and 31 show up a bit-order or field-offset error. Sending mode bits set and then cleared shows whether the flags wrongly stick. A word sent under `init_busy` must neither write nor change `imm_mode`. A design that only gated the strobe would still change the mode flags.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  // positions of the mode bits inside the control field
  localparam int CWR_IMM_BIT = 1;
  localparam int CWR_EXT_BIT = 0;
  localparam int CWR_MODE_N  = 2;
endpackage

// File: rtl/cwr_sync.sv
module cwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] s;

  always_ff @(posedge clk) begin
    if (rst) s <= '0;
    else     s <= {s[STAGES-2:0], d};
  end

  assign q = s[STAGES-1];
endmodule

// File: rtl/cwr_shift.sv
module cwr_shift #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CTRL_W = 2,
  parameter int FILL_W = 1
) (
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              req_tgl,
  output logic [DATA_W-1:0] hold_data,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [CTRL_W-1:0] hold_ctrl
);
  localparam int WORD_W = DATA_W + ADDR_W + CTRL_W + FILL_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam int CTRL_LO = FILL_W;
  localparam int ADDR_LO = FILL_W + CTRL_W;

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-2:0] sh;
  logic [WORD_W-1:0] word;
  logic              last;

  assign last = (cnt == LAST_BIT);
  assign word = {sh, din};

  // a rising chip select throws away any partial word
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n)      cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge sclk) begin
    sh <= {sh[WORD_W-3:0], din};
  end

  always_ff @(posedge sclk or posedge rst) begin
    if (rst) begin
      req_tgl   <= 1'b0;
      hold_data <= '0;
      hold_addr <= '0;
      hold_ctrl <= '0;
    end else if (last) begin
      req_tgl   <= ~req_tgl;
      hold_data <= word[WORD_W-1 -: DATA_W];
      hold_addr <= word[ADDR_LO +: ADDR_W];
      hold_ctrl <= word[CTRL_LO +: CTRL_W];
    end
  end
endmodule

// File: rtl/cwr_wr.sv
module cwr_wr #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_s,
  input  logic              init_busy,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [CTRL_W-1:0] hold_ctrl,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_lat
);
  logic req_d;
  logic take;

  assign take = (req_s ^ req_d) & ~init_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d    <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ctrl_lat <= '0;
    end else begin
      req_d <= req_s;
      wr_en <= take;
      if (take) begin
        wr_addr  <= hold_addr;
        wr_data  <= hold_data;
        ctrl_lat <= hold_ctrl;
      end
    end
  end
endmodule

// File: rtl/cwr_mode.sv
module cwr_mode #(
  parameter int MODE_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_N-1:0] word_bits,
  input  logic [MODE_N-1:0] pin_bits,
  output logic [MODE_N-1:0] mode_q
);
  for (genvar i = 0; i < MODE_N; i++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst) mode_q[i] <= 1'b0;
      else     mode_q[i] <= word_bits[i] | pin_bits[i];
    end
  end
endmodule

// File: rtl/cmd_word_rx.sv
module cmd_word_rx #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              imm_pin,
  input  logic              ext_clk_pin,
  input  logic              init_busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              imm_mode,
  output logic              ext_clk_sel,
  output logic              frame_active
);
  import cwr_pkg::*;

  localparam int CTRL_W = CWR_MODE_N;

  logic              req_tgl, req_s;
  logic [DATA_W-1:0] hold_data;
  logic [ADDR_W-1:0] hold_addr;
  logic [CTRL_W-1:0] hold_ctrl, ctrl_lat, pins, mode_q;

  cwr_shift #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .FILL_W(1)) u_shift (
    .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .req_tgl(req_tgl),
    .hold_data(hold_data), .hold_addr(hold_addr), .hold_ctrl(hold_ctrl));

  cwr_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_tgl), .q(req_s));

  cwr_sync #(.STAGES(SYNC_N)) u_frame_sync (
    .clk(clk), .rst(rst), .d(~cs_n), .q(frame_active));

  cwr_wr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_wr (
    .clk(clk), .rst(rst), .req_s(req_s), .init_busy(init_busy),
    .hold_data(hold_data), .hold_addr(hold_addr), .hold_ctrl(hold_ctrl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_lat(ctrl_lat));

  always_comb begin
    pins = '0;
    pins[CWR_IMM_BIT] = imm_pin;
    pins[CWR_EXT_BIT] = ext_clk_pin;
  end

  cwr_mode #(.MODE_N(CTRL_W)) u_mode (
    .clk(clk), .rst(rst), .word_bits(ctrl_lat), .pin_bits(pins), .mode_q(mode_q));

  assign imm_mode    = mode_q[CWR_IMM_BIT];
  assign ext_clk_sel = mode_q[CWR_EXT_BIT];
endmodule

// File: rtl/cmd_word_rx_chk.sv
module cmd_word_rx_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic imm_pin,
  input logic ext_clk_pin,
  input logic init_busy,
  input logic wr_en,
  input logic imm_mode,
  input logic ext_clk_sel,
  input logic frame_active
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);                                          // R3

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    init_busy |=> !wr_en);                                      // R8

  AST_IMM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && $stable(imm_pin)) |=> $stable(imm_mode));        // R6

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && $stable(ext_clk_pin)) |=> $stable(ext_clk_sel)); // R6

  AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 2) && $past(cs_n, 3)) |-> !frame_active);      // R9

  AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(cs_n, 2) && !$past(cs_n, 3)) |-> frame_active);     // R9
endmodule

bind cmd_word_rx cmd_word_rx_chk u_chk (.*);

// File: tb/cmd_word_rx_tb.sv
module cmd_word_rx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic imm_pin = 1'b0, ext_clk_pin = 1'b0, init_busy = 1'b0;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic        imm_mode, ext_clk_sel, frame_active;

  int total = 0, bad = 0;
  int n_wr = 0;
  logic [4:0]  log_addr [0:7];
  logic [15:0] log_data [0:7];
  bit done = 0;

  always #2 clk = ~clk;

  cmd_word_rx u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .imm_pin(imm_pin), .ext_clk_pin(ext_clk_pin), .init_busy(init_busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .imm_mode(imm_mode), .ext_clk_sel(ext_clk_sel), .frame_active(frame_active));

  // write monitor at the falling edge
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      log_addr[n_wr % 8] <= wr_addr;
      log_data[n_wr % 8] <= wr_data;
      n_wr <= n_wr + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    #40;
  endtask

  task automatic close_frame();
    #32 sclk = 1'b0;
    cs_n = 1'b1;
    wait_clk(20);
  endtask

  task automatic send_bits(logic [23:0] w, int nbits);
    for (int i = 23; i > 23 - nbits; i--) begin
      sclk = 1'b0;
      din  = w[i];
      #32 sclk = 1'b1;
      #32;
    end
  endtask

  function automatic logic [23:0] mk(logic [15:0] d, logic [4:0] a, logic c1, logic c0);
    return {d, a, c1, c0, 1'b0};
  endfunction

  task automatic t_reset();
    check("R10 wr_en", wr_en, 0);
    check("R10 wr_addr", wr_addr, 0);
    check("R10 wr_data", wr_data, 0);
    check("R10 imm_mode", imm_mode, 0);
    check("R10 ext_clk_sel", ext_clk_sel, 0);
    check("R10 frame_active", frame_active, 0);
  endtask

  task automatic t_single();
    int b = n_wr;
    open_frame();
    send_bits(mk(16'h8001, 5'd7, 1'b0, 1'b0), 24);
    wait_clk(8);
    check("R3 one write", n_wr - b, 1);
    check("R1 data msb first", log_data[b % 8], 16'h8001);
    check("R2 address field", log_addr[b % 8], 5'd7);
    close_frame();
  endtask

  task automatic t_multi();
    int b = n_wr;
    open_frame();
    send_bits(mk(16'hA5C3, 5'd0, 1'b0, 1'b0), 24);
    send_bits(mk(16'h1234, 5'd31, 1'b0, 1'b0), 24);
    send_bits(mk(16'h0F0F, 5'd18, 1'b0, 1'b0), 24);
    close_frame();
    check("R4 three writes", n_wr - b, 3);
    check("R4 first addr", log_addr[b % 8], 5'd0);
    check("R4 first data", log_data[b % 8], 16'hA5C3);
    check("R3 addr 31", log_addr[(b + 1) % 8], 5'd31);
    check("R4 second data", log_data[(b + 1) % 8], 16'h1234);
    check("R4 third addr", log_addr[(b + 2) % 8], 5'd18);
    check("R4 third data", log_data[(b + 2) % 8], 16'h0F0F);
  endtask

  task automatic t_partial();
    int b = n_wr;
    open_frame();
    send_bits(mk(16'hFFFF, 5'd31, 1'b1, 1'b1), 10);
    close_frame();
    check("R5 partial no write", n_wr - b, 0);
    check("R5 partial no mode", {imm_mode, ext_clk_sel}, 2'b00);
    open_frame();
    send_bits(mk(16'h3C5A, 5'd5, 1'b0, 1'b0), 24);
    close_frame();
    check("R5 next frame writes once", n_wr - b, 1);
    check("R5 realigned addr", log_addr[b % 8], 5'd5);
    check("R5 realigned data", log_data[b % 8], 16'h3C5A);
  endtask

  task automatic t_modes();
    open_frame();
    send_bits(mk(16'h0001, 5'd1, 1'b1, 1'b0), 24);
    close_frame();
    check("R6 imm set", imm_mode, 1);
    check("R6 ext clear", ext_clk_sel, 0);
    open_frame();
    send_bits(mk(16'h0002, 5'd2, 1'b0, 1'b1), 24);
    close_frame();
    check("R6 imm cleared by word", imm_mode, 0);
    check("R6 ext set", ext_clk_sel, 1);
    open_frame();
    send_bits(mk(16'h0003, 5'd3, 1'b0, 1'b0), 24);
    close_frame();
    check("R6 ext not sticky", ext_clk_sel, 0);
  endtask

  task automatic t_pins();
    imm_pin = 1'b1;
    wait_clk(2);
    check("R7 imm pin", imm_mode, 1);
    check("R7 ext unaffected", ext_clk_sel, 0);
    imm_pin = 1'b0;
    ext_clk_pin = 1'b1;
    wait_clk(2);
    check("R7 imm pin released", imm_mode, 0);
    check("R7 ext pin", ext_clk_sel, 1);
    open_frame();
    send_bits(mk(16'h0004, 5'd4, 1'b1, 1'b0), 24);
    close_frame();
    check("R7 word or pin imm", imm_mode, 1);
    check("R7 pin wins ext", ext_clk_sel, 1);
    ext_clk_pin = 1'b0;
    wait_clk(2);
    check("R7 ext back to word bit", ext_clk_sel, 0);
  endtask

  task automatic t_busy();
    int b = n_wr;
    init_busy = 1'b1;
    open_frame();
    send_bits(mk(16'hBEEF, 5'd9, 1'b0, 1'b1), 24);
    close_frame();
    check("R8 no write while busy", n_wr - b, 0);
    check("R8 imm kept", imm_mode, 1);
    check("R8 ext kept", ext_clk_sel, 0);
    init_busy = 1'b0;
    wait_clk(2);
    open_frame();
    send_bits(mk(16'h4321, 5'd9, 1'b0, 1'b0), 24);
    close_frame();
    check("R8 write after busy", n_wr - b, 1);
    check("R8 data after busy", log_data[b % 8], 16'h4321);
    check("R8 mode after busy", imm_mode, 0);
  endtask

  task automatic t_frame();
    cs_n = 1'b0;
    wait_clk(6);
    check("R9 frame open", frame_active, 1);
    cs_n = 1'b1;
    wait_clk(6);
    check("R9 frame closed", frame_active, 0);
  endtask

  initial begin
    wait_clk(10);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_single();
    t_multi();
    t_partial();
    t_modes();
    t_pins();
    t_busy();
    t_frame();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule